// File: doc/BRIEF.md
# Streaming CRC Engine

This block computes a cyclic redundancy check over a stream of data words. The CRC algorithm is fixed when the block is built. Its parameters are:

- the CRC width
- the generator polynomial
- the seed value
- whether input words are bit-reversed
- whether the result is bit-reversed
- the final XOR mask

The input word width is a separate parameter, so a 32-bit CRC can be computed over 8-bit words. On every clock cycle with `valid` high, the block absorbs a whole word in one step.

A `start` strobe reloads the seed. It works with or without `valid`, so a message can be restarted at any time. When `start` and `valid` are high together, that word becomes the first word of a fresh message. The finished CRC is driven combinationally from the state register. A `match` flag rises when the raw register holds the residue constant. That constant is what any intact message leaves behind once its own CRC has been appended in transmission order.

Top module: `crc_stream_engine`

## Requirements
- R1: With width 8, polynomial 0x2F, seed 0xFF, no reflection and XOR mask 0xFF, the ASCII bytes "123456789" give the CRC 0xDF.
- R2: With width 8, polynomial 0xA7, seed 0x00, both reflections on and XOR mask 0x00, the same bytes give 0x26.
- R3: A 32-bit CRC (polynomial 0x04C11DB7, seed 0xFFFFFFFF, both reflections on, mask 0xFFFFFFFF) over 8-bit words gives 0xCBF43926 for "123456789".
- R4: A synchronous reset loads the seed, so `crc` equals the transformed seed on the cycle after reset.
- R5: With `start` and `valid` both low, the register and `crc` hold their values.
- R6: `start` with `valid` low reloads the seed, whatever the register held before.
- R7: `start` with `valid` high processes the word from the seed, so repeating that cycle with the same word gives the same `crc`.
- R8: With input reflection on, each word is absorbed from bit 0 upward; with it off, from the top bit downward. Each valid cycle absorbs exactly one word, and `crc` shows the result on the cycle after.
- R9: `crc` is the register, bit-reversed when output reflection is on, XORed with the mask.
- R10: `match` is high after a message followed by its CRC has been absorbed. The CRC is appended low byte first when reflected and high byte first when not. `match` is low after the message alone when the register differs from the residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, loads the seed |
| start | input | 1 | Reload the seed, independent of valid |
| valid | input | 1 | Absorb `data` this cycle |
| data | input | DATA_W | Input word |
| crc | output | CRC_W | Finished CRC of the words absorbed so far |
| match | output | 1 | Register equals the residue constant |

## Verification
The bench builds three copies of the engine:

- An 8-bit non-reflected algorithm with seed and mask 0xFF. This copy exercises most-significant-bit-first absorption and a non-zero mask.
- An 8-bit reflected algorithm with polynomial 0xA7. This copy exercises least-significant-bit-first absorption and output reversal.
- A 32-bit reflected algorithm over 8-bit words. This copy covers a data word narrower than the CRC, and a residue check that needs a four-byte trailer appended low byte first.

All three copies are compared each cycle against a bit-serial model in the bench, which keeps the reflected algorithms in mirrored register form.

// File: rtl/crc_stream_engine.sv
module crc_stream_engine #(
  parameter int CRC_W = 8,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 'h2F,
  parameter logic [CRC_W-1:0] INIT = 'hFF,
  parameter bit REFIN = 1'b0,
  parameter bit REFOUT = 1'b0,
  parameter logic [CRC_W-1:0] XOROUT = 'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc,
  output logic              match
);

  function automatic logic [CRC_W-1:0] shift_in(input logic [CRC_W-1:0] r, input logic b);
    logic fb;
    fb = r[CRC_W-1] ^ b;
    return fb ? ((r << 1) ^ POLY) : (r << 1);
  endfunction

  function automatic logic [CRC_W-1:0] absorb(input logic [CRC_W-1:0] r, input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] acc;
    acc = r;
    for (int i = 0; i < DATA_W; i++)
      acc = shift_in(acc, REFIN ? d[i] : d[DATA_W-1-i]);
    return acc;
  endfunction

  function automatic logic [CRC_W-1:0] finish(input logic [CRC_W-1:0] r);
    logic [CRC_W-1:0] o;
    for (int i = 0; i < CRC_W; i++)
      o[i] = REFOUT ? r[CRC_W-1-i] : r[i];
    return o ^ XOROUT;
  endfunction

  function automatic logic [CRC_W-1:0] residue_of();
    logic [CRC_W-1:0] r;
    logic [CRC_W-1:0] o;
    r = INIT;
    o = finish(INIT);
    for (int i = 0; i < CRC_W; i++)
      r = shift_in(r, REFIN ? o[i] : o[CRC_W-1-i]);
    return r;
  endfunction

  localparam logic [CRC_W-1:0] RESIDUE = residue_of();

  logic [CRC_W-1:0] state_q;
  logic [CRC_W-1:0] seed;
  logic [CRC_W-1:0] state_d;

  assign seed    = start ? INIT : state_q;
  assign state_d = valid ? absorb(seed, data) : seed;

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= INIT;
    else if (start || valid)
      state_q <= state_d;
  end

  assign crc   = finish(state_q);
  assign match = (state_q == RESIDUE);

endmodule

// File: rtl/crc_stream_engine_chk.sv
module crc_stream_engine_chk #(
  parameter int CRC_W = 8,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 'h2F,
  parameter logic [CRC_W-1:0] INIT = 'hFF,
  parameter bit REFIN = 1'b0,
  parameter bit REFOUT = 1'b0,
  parameter logic [CRC_W-1:0] XOROUT = 'hFF
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              valid,
  input logic [DATA_W-1:0] data,
  input logic [CRC_W-1:0]  crc,
  input logic              match
);

  function automatic logic [CRC_W-1:0] seed_out();
    logic [CRC_W-1:0] m;
    for (int i = 0; i < CRC_W; i++)
      m[CRC_W-1-i] = INIT[i];
    return (REFOUT ? m : INIT) ^ XOROUT;
  endfunction

  localparam logic [CRC_W-1:0] SEED_OUT = seed_out();

  logic              sv_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sv_q   <= 1'b0;
      data_q <= '0;
    end else begin
      sv_q   <= start && valid;
      data_q <= data;
    end
  end

  AST_RESET_SEED: assert property (@(posedge clk) rst |=> crc == SEED_OUT); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!start && !valid) |=> $stable(crc)); // R5

  AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!start && !valid) |=> $stable(match)); // R10

  AST_START_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (start && !valid) |=> crc == SEED_OUT); // R6

  AST_START_FRESH: assert property (@(posedge clk) disable iff (rst)
    (start && valid && sv_q && data == data_q) |=> $stable(crc)); // R7

endmodule

bind crc_stream_engine crc_stream_engine_chk #(
  .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .INIT(INIT),
  .REFIN(REFIN), .REFOUT(REFOUT), .XOROUT(XOROUT)
) u_chk (.*);

// File: tb/crc_stream_engine_test.sv
`timescale 1ns/1ps
module crc_stream_engine_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic valid = 1'b0;
  logic [7:0] da = '0, db = '0, dc = '0;
  logic [7:0]  crc_a, crc_b;
  logic [31:0] crc_c;
  logic match_a, match_b, match_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crc_stream_engine uut (
    .clk(clk), .rst(rst), .start(start), .valid(valid), .data(da),
    .crc(crc_a), .match(match_a));

  crc_stream_engine #(.CRC_W(8), .DATA_W(8), .POLY(8'hA7), .INIT(8'h00),
    .REFIN(1'b1), .REFOUT(1'b1), .XOROUT(8'h00)) uut_bt (
    .clk(clk), .rst(rst), .start(start), .valid(valid), .data(db),
    .crc(crc_b), .match(match_b));

  crc_stream_engine #(.CRC_W(32), .DATA_W(8), .POLY(32'h04C11DB7), .INIT(32'hFFFFFFFF),
    .REFIN(1'b1), .REFOUT(1'b1), .XOROUT(32'hFFFFFFFF)) uut_32 (
    .clk(clk), .rst(rst), .start(start), .valid(valid), .data(dc),
    .crc(crc_c), .match(match_c));

  // bench models: A in plain form, B and C in mirrored register form
  logic [7:0]  m_a;
  logic [31:0] m_b, m_c;

  function automatic logic [7:0] mdl_msb(input logic [7:0] r, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h2F;
    end
    return r;
  endfunction

  function automatic logic [31:0] mdl_lsb(input logic [31:0] r, input logic [31:0] rpoly, input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ rpoly;
    end
    return r;
  endfunction

  task automatic model_reset();
    m_a = 8'hFF; m_b = 32'h0; m_c = 32'hFFFFFFFF;
  endtask

  task automatic step(input bit s, input bit v, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    start = s; valid = v; da = a; db = b; dc = c;
    if (s) model_reset();
    if (v) begin
      m_a = mdl_msb(m_a, a);
      m_b = mdl_lsb(m_b, 32'h000000E5, b);
      m_c = mdl_lsb(m_c, 32'hEDB88320, c);
    end
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; valid = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_model(input string req);
    chk(req, {24'h0, crc_a}, {24'h0, m_a ^ 8'hFF});
    chk(req, {24'h0, crc_b}, m_b);
    chk(req, crc_c, m_c ^ 32'hFFFFFFFF);
  endtask

  localparam logic [7:0] MSG [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

  // {start, valid, data}
  localparam logic [9:0] VEC [13] = '{
    {2'b11, 8'h31}, {2'b01, 8'h32}, {2'b00, 8'h00}, {2'b01, 8'h33},
    {2'b10, 8'hAA}, {2'b01, 8'h34}, {2'b11, 8'h35}, {2'b11, 8'h35},
    {2'b01, 8'h00}, {2'b01, 8'hFF}, {2'b00, 8'h12}, {2'b01, 8'h80},
    {2'b01, 8'h01}};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep_a, keep_c;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R4 / R9: seed after reset, transformed for output
    chk("R4", {24'h0, crc_a}, 32'h00);
    chk("R4", {24'h0, crc_b}, 32'h00);
    chk("R9", crc_c, 32'h0);

    // R8 table walk against bit-serial models
    for (int i = 0; i < 13; i++) begin
      step(VEC[i][9], VEC[i][8], VEC[i][7:0], VEC[i][7:0], VEC[i][7:0]);
      chk_model("R8");
    end

    // R1 R2 R3 published check values
    for (int i = 0; i < 9; i++)
      step(i == 0, 1'b1, MSG[i], MSG[i], MSG[i]);
    chk("R1", {24'h0, crc_a}, 32'hDF);
    chk("R2", {24'h0, crc_b}, 32'h26);
    chk("R3", crc_c, 32'hCBF43926);
    chk("R10", {31'h0, match_a}, 32'h0);

    // R5 idle holds
    keep_a = {24'h0, crc_a}; keep_c = crc_c;
    repeat (3) step(1'b0, 1'b0, 8'h55, 8'h55, 8'h55);
    chk("R5", {24'h0, crc_a}, keep_a);
    chk("R5", crc_c, keep_c);

    // R10 append own CRC: 8-bit ones one byte, 32-bit low byte first
    step(1'b0, 1'b1, 8'hDF, 8'h26, 8'h26);
    chk("R10", {31'h0, match_a}, 32'h1);
    chk("R10", {31'h0, match_b}, 32'h1);
    chk("R10", {31'h0, match_c}, 32'h0);
    step(1'b0, 1'b1, 8'h00, 8'h00, 8'h39);
    step(1'b0, 1'b1, 8'h00, 8'h00, 8'hF4);
    step(1'b0, 1'b1, 8'h00, 8'h00, 8'hCB);
    chk("R10", {31'h0, match_c}, 32'h1);
    chk_model("R8");

    // R6 start without valid
    step(1'b1, 1'b0, 8'h77, 8'h77, 8'h77);
    chk("R6", {24'h0, crc_a}, 32'h00);
    chk("R6", crc_c, 32'h0);
    chk("R10", {31'h0, match_c}, 32'h0);

    // R7 start with valid restarts from seed
    step(1'b0, 1'b1, 8'h9C, 8'h9C, 8'h9C);
    step(1'b1, 1'b1, 8'h31, 8'h31, 8'h31);
    keep_a = {24'h0, crc_a}; keep_c = crc_c;
    step(1'b1, 1'b1, 8'h31, 8'h31, 8'h31);
    chk("R7", {24'h0, crc_a}, keep_a);
    chk("R7", crc_c, keep_c);
    chk_model("R7");

    // R4 mid-stream reset
    step(1'b0, 1'b1, 8'hE1, 8'hE1, 8'hE1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R4", {24'h0, crc_a}, 32'h00);
    chk("R4", crc_c, 32'h0);
    chk_model("R4");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule